// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a running time of day as a 32-bit seconds count and a nanoseconds count that rolls over at one billion. Software reaches it through a small word-wide register port. It stages a seconds value and a nanoseconds value in shadow registers. It then sets one of three command bits in a control word: load the staged time, step the running time by the staged amount, or move a staged rate word into the active rate path. Each command bit stays set while it is pending and clears itself once the hardware has acted, so software polls it to learn that the command has completed.

The time advances by a programmable nanosecond increment, and only while the enable bit is set. In coarse mode the increment is added on every clock. In fine mode a 32-bit rate word is added to a 32-bit phase accumulator on every clock, and the increment is applied only on the cycles where the accumulator carries out. The average tick rate is therefore the rate word divided by 2^32 of the clock. That fraction is the knob for frequency trimming.

The time is also driven straight onto output pins for local consumers. A read of the seconds word captures the matching nanoseconds value into a holding word, so that a two-word read through the register port is coherent.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time is 0 s / 0 ns, the control word reads 0 and the staged rate word reads 0.
- R2: Register map, by word address: 0 control, 1 staged seconds, 2 staged nanoseconds, 3 staged rate word, 4 nanosecond increment (low 8 bits), 5 live seconds, 6 held nanoseconds, 7 live nanoseconds. Control bits: [0] enable, [1] fine mode, [2] load command, [3] step command, [4] rate-load command, [5] step direction (1 = subtract). The clock edge after the load command is registered, the time equals the staged seconds and nanoseconds exactly, with no increment added in that cycle.
- R3: A command bit reads back as 1 when the read is taken in the cycle after the command is written. It reads back as 0 from the following cycle on.
- R4: A step with direction 0 adds the staged value to the time. A nanosecond sum of one billion or more wraps and carries one into the seconds.
- R5: A step with direction 1 subtracts the staged value from the time. When the staged nanoseconds exceed the current nanoseconds, the result borrows one second and adds one billion nanoseconds.
- R6: With enable set and fine mode clear, the time advances by the increment on every clock.
- R7: With enable and fine mode set, the increment is applied only on accumulator carry-out. A rate word of 2^31 gives exactly 32 increments in any 64-cycle window, and 2^30 gives 16.
- R8: Writing the staged rate word has no effect on the count rate until a rate-load command is issued.
- R9: When the nanoseconds would reach one billion or more after an increment, they wrap, and the seconds count goes up by one. The nanoseconds never reach one billion.
- R10: With enable clear and no command pending, the time does not change.
- R11: A read of address 5 returns the seconds and captures the nanoseconds of the same cycle. A later read of address 6 returns that captured value, even after a rollover in between.
- R12: When the load and step commands are pending together, the load is applied and the step is discarded. A rate-load command pending in the same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | Marks the cycle rd_data is valid |
| tod_sec | output | 32 | Live seconds count |
| tod_ns | output | 30 | Live nanoseconds count |

## Verification
The nanosecond range check and the step arithmetic assume legal inputs. Software must stage nanosecond values below one billion, and the increment must stay small next to one billion, which its 8-bit field guarantees. The stimulus therefore writes only staged nanoseconds in range. Command bits are not rewritten while they are pending, except in the single deliberate case where all three commands are issued together. The rate checks measure windows of 64 cycles whose length is a whole number of accumulator periods, so the expected tick count does not depend on the accumulator's starting phase.

// File: rtl/ptp_tc_pkg.sv
// Package: shared constants and register addresses for the PTP time counter.
// Assumes a 32-bit register data path and a nanoseconds field that wraps at 1e9.
package ptp_tc_pkg;

    localparam int DATA_W = 32;
    localparam int NS_W   = 30;
    localparam logic [NS_W:0] NS_LIMIT = 31'd1_000_000_000;

    typedef enum logic [2:0] {
        A_CTRL     = 3'd0,
        A_STG_SEC  = 3'd1,
        A_STG_NS   = 3'd2,
        A_STG_RATE = 3'd3,
        A_INCR     = 3'd4,
        A_LIVE_SEC = 3'd5,
        A_HELD_NS  = 3'd6,
        A_LIVE_NS  = 3'd7
    } reg_addr_e;

    localparam int CB_EN    = 0;
    localparam int CB_FINE  = 1;
    localparam int CB_LOAD  = 2;
    localparam int CB_STEP  = 3;
    localparam int CB_RATE  = 4;
    localparam int CB_SUB   = 5;
    localparam int N_CMD    = 3;

endpackage

// File: rtl/ptp_tc_regs.sv
// Module: register file of the time counter. Holds the control word, staged
// time, staged rate word and increment, the pending command bits and the
// read mux with the nanoseconds holding word.
// Assumes: command acknowledges come from the datapath in the cycle a command
// is consumed; reads return one cycle after rd_en.
module ptp_tc_regs
    import ptp_tc_pkg::*;
#(
    parameter int SEC_W    = 32,
    parameter int INCR_W   = 8,
    parameter int RATE_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [2:0]           rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    input  logic [SEC_W-1:0]     cur_sec,
    input  logic [NS_W-1:0]      cur_ns,
    input  logic [N_CMD-1:0]     cmd_ack,
    output logic [N_CMD-1:0]     cmd_pend,
    output logic                 run_en,
    output logic                 fine_mode,
    output logic                 step_sub,
    output logic [SEC_W-1:0]     stg_sec,
    output logic [NS_W-1:0]      stg_ns,
    output logic [RATE_W-1:0]    stg_rate,
    output logic [INCR_W-1:0]    incr
);

    logic               ctrl_wr;
    logic [N_CMD-1:0]   cmd_set;
    logic [NS_W-1:0]    held_ns;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign cmd_set = ctrl_wr ? wr_data[CB_RATE:CB_LOAD] : '0;

    // Purpose: capture mode bits and staged values written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en    <= 1'b0;
            fine_mode <= 1'b0;
            step_sub  <= 1'b0;
            stg_sec   <= '0;
            stg_ns    <= '0;
            stg_rate  <= '0;
            incr      <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    run_en    <= wr_data[CB_EN];
                    fine_mode <= wr_data[CB_FINE];
                    step_sub  <= wr_data[CB_SUB];
                end
                A_STG_SEC:  stg_sec  <= wr_data[SEC_W-1:0];
                A_STG_NS:   stg_ns   <= wr_data[NS_W-1:0];
                A_STG_RATE: stg_rate <= wr_data[RATE_W-1:0];
                A_INCR:     incr     <= wr_data[INCR_W-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: pending command bits, set by software and cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_pend <= '0;
        end else begin
            for (int i = 0; i < N_CMD; i++) begin
                cmd_pend[i] <= (cmd_pend[i] && !cmd_ack[i]) || cmd_set[i];
            end
        end
    end

    // Purpose: registered read mux; a seconds read captures the nanoseconds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            held_ns  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                case (rd_addr)
                    A_CTRL: begin
                        rd_data          <= '0;
                        rd_data[CB_EN]   <= run_en;
                        rd_data[CB_FINE] <= fine_mode;
                        rd_data[CB_RATE:CB_LOAD] <= cmd_pend;
                        rd_data[CB_SUB]  <= step_sub;
                    end
                    A_STG_SEC:  rd_data <= DATA_W'(stg_sec);
                    A_STG_NS:   rd_data <= DATA_W'(stg_ns);
                    A_STG_RATE: rd_data <= DATA_W'(stg_rate);
                    A_INCR:     rd_data <= DATA_W'(incr);
                    A_LIVE_SEC: begin
                        rd_data <= DATA_W'(cur_sec);
                        held_ns <= cur_ns;
                    end
                    A_HELD_NS:  rd_data <= DATA_W'(held_ns);
                    default:    rd_data <= DATA_W'(cur_ns);
                endcase
            end
        end
    end

    // R3
    cmd_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pend != '0) && (cmd_set == '0) |=> (cmd_pend == '0));

    // R11
    held_ns_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (rd_addr == A_LIVE_SEC) |=> (held_ns == $past(cur_ns)));

    // R3
    cmd_set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && wr_data[CB_LOAD] |=> cmd_pend[0]);

endmodule

// File: rtl/ptp_tc_rate.sv
// Module: rate generator. Holds the active rate word and the phase accumulator
// and decides in which cycles the time takes an increment.
// Assumes: the rate-load request is a level that is consumed in one cycle.
module ptp_tc_rate #(
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              fine_mode,
    input  logic [RATE_W-1:0] stg_rate,
    input  logic              rate_req,
    output logic              rate_ack,
    output logic              tick
);

    logic [RATE_W-1:0] act_rate;
    logic [RATE_W-1:0] phase;
    logic [RATE_W:0]   phase_sum;

    assign rate_ack  = rate_req;
    assign phase_sum = {1'b0, phase} + {1'b0, act_rate};
    assign tick      = run_en && (fine_mode ? phase_sum[RATE_W] : 1'b1);

    // Purpose: move the staged rate word into the active path on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        act_rate <= '0;
        else if (rate_req) act_rate <= stg_rate;
    end

    // Purpose: advance the phase accumulator while running in fine mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                      phase <= '0;
        else if (run_en && fine_mode)    phase <= phase_sum[RATE_W-1:0];
    end

    // R8
    rate_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_req |=> (act_rate == $past(stg_rate)));

    // R8
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_req |=> $stable(act_rate));

    // R7
    zero_rate_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fine_mode && (act_rate == '0) |-> !tick);

endmodule

// File: rtl/ptp_tc_core.sv
// Module: time-of-day datapath. Holds seconds and nanoseconds and applies,
// in priority order, a load, a signed step or an increment.
// Assumes: staged nanoseconds below 1e9 and an increment far below 1e9.
module ptp_tc_core
    import ptp_tc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int INCR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [INCR_W-1:0] incr,
    input  logic              load_req,
    input  logic              step_req,
    input  logic              step_sub,
    input  logic [SEC_W-1:0]  stg_sec,
    input  logic [NS_W-1:0]   stg_ns,
    output logic              load_ack,
    output logic              step_ack,
    output logic [SEC_W-1:0]  sec_q,
    output logic [NS_W-1:0]   ns_q
);

    logic [NS_W:0]    tick_sum;
    logic [NS_W-1:0]  tick_ns;
    logic [SEC_W-1:0] tick_sec;
    logic [NS_W:0]    add_sum;
    logic [NS_W-1:0]  step_ns;
    logic [SEC_W-1:0] step_sec;
    logic             carry;

    assign load_ack = load_req;
    assign step_ack = step_req;

    // Purpose: next time for an increment, with rollover into the seconds.
    always_comb begin
        tick_sum = {1'b0, ns_q} + (NS_W+1)'(incr);
        if (tick_sum >= NS_LIMIT) begin
            tick_ns  = NS_W'(tick_sum - NS_LIMIT);
            tick_sec = sec_q + SEC_W'(1);
        end else begin
            tick_ns  = tick_sum[NS_W-1:0];
            tick_sec = sec_q;
        end
    end

    // Purpose: next time for a signed step, carrying or borrowing a second.
    always_comb begin
        add_sum = {1'b0, ns_q} + {1'b0, stg_ns};
        carry   = 1'b0;
        if (step_sub) begin
            if (ns_q >= stg_ns) begin
                step_ns = ns_q - stg_ns;
            end else begin
                step_ns = NS_W'({1'b0, ns_q} + NS_LIMIT - {1'b0, stg_ns});
                carry   = 1'b1;
            end
            step_sec = sec_q - stg_sec - SEC_W'(carry);
        end else begin
            if (add_sum >= NS_LIMIT) begin
                step_ns = NS_W'(add_sum - NS_LIMIT);
                carry   = 1'b1;
            end else begin
                step_ns = add_sum[NS_W-1:0];
            end
            step_sec = sec_q + stg_sec + SEC_W'(carry);
        end
    end

    // Purpose: time register; load beats step beats increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else if (load_req) begin
            sec_q <= stg_sec;
            ns_q  <= stg_ns;
        end else if (step_req) begin
            sec_q <= step_sec;
            ns_q  <= step_ns;
        end else if (tick) begin
            sec_q <= tick_sec;
            ns_q  <= tick_ns;
        end
    end

    // R9
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_q < NS_W'(NS_LIMIT)));

    // R2
    load_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (sec_q == $past(stg_sec)) && (ns_q == $past(stg_ns)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !load_req && !step_req |=> $stable(sec_q) && $stable(ns_q));

    // R6
    tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load_req && !step_req |=>
            ((ns_q == $past(ns_q) + NS_W'($past(incr))) && $stable(sec_q)) ||
            (sec_q == $past(sec_q) + SEC_W'(1)));

endmodule

// File: rtl/ptp_time_counter.sv
// Module: top of the PTP time-of-day counter. Connects the register file,
// the rate generator and the time datapath, and exposes the live time.
// Assumes: a single clock domain for register access and counting.
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int INCR_W = 8,
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns
);

    logic [N_CMD-1:0]  cmd_pend;
    logic [N_CMD-1:0]  cmd_ack;
    logic              run_en;
    logic              fine_mode;
    logic              step_sub;
    logic [SEC_W-1:0]  stg_sec;
    logic [NS_W-1:0]   stg_ns;
    logic [RATE_W-1:0] stg_rate;
    logic [INCR_W-1:0] incr;
    logic              tick;
    logic              load_ack;
    logic              step_ack;
    logic              rate_ack;

    assign cmd_ack = {rate_ack, step_ack, load_ack};

    ptp_tc_regs #(.SEC_W(SEC_W), .INCR_W(INCR_W), .RATE_W(RATE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .cur_sec(tod_sec), .cur_ns(tod_ns),
        .cmd_ack(cmd_ack), .cmd_pend(cmd_pend),
        .run_en(run_en), .fine_mode(fine_mode), .step_sub(step_sub),
        .stg_sec(stg_sec), .stg_ns(stg_ns), .stg_rate(stg_rate), .incr(incr)
    );

    ptp_tc_rate #(.RATE_W(RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n),
        .run_en(run_en), .fine_mode(fine_mode),
        .stg_rate(stg_rate), .rate_req(cmd_pend[2]), .rate_ack(rate_ack),
        .tick(tick)
    );

    ptp_tc_core #(.SEC_W(SEC_W), .INCR_W(INCR_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .tick(tick), .incr(incr),
        .load_req(cmd_pend[0]), .step_req(cmd_pend[1]), .step_sub(step_sub),
        .stg_sec(stg_sec), .stg_ns(stg_ns),
        .load_ack(load_ack), .step_ack(step_ack),
        .sec_q(tod_sec), .ns_q(tod_ns)
    );

    // R12
    load_over_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pend[0] && cmd_pend[1] |=> (tod_sec == $past(stg_sec)) && (tod_ns == $past(stg_ns)));

endmodule

// File: tb/test_ptp_time_counter.sv
module test_ptp_time_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [31:0] tod_sec;
    logic [29:0] tod_ns;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    logic [31:0] mask_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_time_counter i_ptp_time_counter (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .tod_sec(tod_sec), .tod_ns(tod_ns)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one-cycle register write, starting just after a falling edge.
    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: one-cycle read; pushes the expected word for the monitor.
    task automatic reg_rd(input logic [2:0] a, input logic [31:0] exp,
                          input logic [31:0] mask, input string tag);
        exp_q.push_back(exp); mask_q.push_back(mask); tag_q.push_back(tag);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_time(input string tag, input logic [31:0] s, input logic [29:0] ns);
        check({tag, " sec"}, tod_sec, s);
        check({tag, " ns"}, 32'(tod_ns), 32'(ns));
    endtask

    // Monitor: pop and compare read results away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL unexpected read actual=%0d expected=none", rd_data);
            end else begin
                logic [31:0] e, m;
                string t;
                e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
                check(t, rd_data & m, e & m);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [29:0] t0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_time("R1 reset", 32'd0, 30'd0);
        reg_rd(3'd0, 32'h0, 32'hFFFF_FFFF, "R1 ctrl after reset");
        reg_rd(3'd3, 32'h0, 32'hFFFF_FFFF, "R1 rate word after reset");

        // R2 load, R3 self-clearing command bit
        reg_wr(3'd4, 32'd8);
        reg_wr(3'd1, 32'd5);
        reg_wr(3'd2, 32'd999_999_998);
        reg_wr(3'd0, 32'h04);
        reg_rd(3'd0, 32'h04, 32'h1C, "R3 load bit pending");
        reg_rd(3'd0, 32'h00, 32'h1C, "R3 load bit cleared");
        check_time("R2 load", 32'd5, 30'd999_999_998);

        // R10 disabled time holds
        wait_cyc(10);
        check_time("R10 hold while disabled", 32'd5, 30'd999_999_998);

        // R11 coherent read across rollover, R9 rollover
        reg_wr(3'd0, 32'h01);
        reg_rd(3'd5, 32'd5, 32'hFFFF_FFFF, "R11 live seconds");
        check_time("R9 rollover", 32'd6, 30'd6);
        reg_rd(3'd6, 32'd999_999_998, 32'hFFFF_FFFF, "R11 held nanoseconds");

        // R6 coarse mode: +8 ns per clock
        t0 = tod_ns;
        wait_cyc(10);
        check("R6 coarse advance", 32'(tod_ns), 32'(t0) + 32'd80);
        reg_wr(3'd0, 32'h00);

        // R4 step add with carry
        reg_wr(3'd1, 32'd10);
        reg_wr(3'd2, 32'd999_999_900);
        reg_wr(3'd0, 32'h04);
        reg_wr(3'd1, 32'd2);
        reg_wr(3'd2, 32'd300);
        reg_wr(3'd0, 32'h08);
        wait_cyc(1);
        check_time("R4 step add", 32'd13, 30'd200);

        // R5 step subtract with borrow
        reg_wr(3'd1, 32'd10);
        reg_wr(3'd2, 32'd100);
        reg_wr(3'd0, 32'h04);
        reg_wr(3'd1, 32'd3);
        reg_wr(3'd2, 32'd200);
        reg_wr(3'd0, 32'h28);
        wait_cyc(1);
        check_time("R5 step subtract", 32'd6, 30'd999_999_900);

        // R8 staged rate word has no effect before its load command
        reg_wr(3'd4, 32'd20);
        reg_wr(3'd1, 32'd1);
        reg_wr(3'd2, 32'd0);
        reg_wr(3'd0, 32'h04);
        reg_wr(3'd0, 32'h03);
        wait_cyc(16);
        check_time("R8 zero rate holds", 32'd1, 30'd0);
        reg_wr(3'd3, 32'h8000_0000);
        wait_cyc(16);
        check_time("R8 unloaded rate holds", 32'd1, 30'd0);
        reg_rd(3'd3, 32'h8000_0000, 32'hFFFF_FFFF, "R8 staged rate readback");

        // R7 fine mode rate 1/2
        reg_wr(3'd0, 32'h13);
        wait_cyc(3);
        t0 = tod_ns;
        wait_cyc(64);
        check("R7 fine half rate", 32'(tod_ns), 32'(t0) + 32'd640);
        reg_wr(3'd0, 32'h00);

        // R12 load beats step; rate load proceeds
        reg_wr(3'd3, 32'h4000_0000);
        reg_wr(3'd1, 32'd100);
        reg_wr(3'd2, 32'd50);
        reg_wr(3'd0, 32'h1C);
        wait_cyc(1);
        check_time("R12 load wins over step", 32'd100, 30'd50);
        reg_rd(3'd0, 32'h00, 32'h1C, "R12 all commands cleared");
        reg_wr(3'd0, 32'h03);
        wait_cyc(2);
        t0 = tod_ns;
        wait_cyc(64);
        check("R12 R7 quarter rate after joint load", 32'(tod_ns), 32'(t0) + 32'd320);

        wait_cyc(3);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL reads pending actual=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule